// File: doc/BRIEF.md
# PLL Mode and Lock-Break Controller

This block supervises a frequency-synthesizing PLL core. It holds a 16-bit control and status register and runs a three-state mode machine: bypass, acquiring and locked. It watches the core's lock indication and keeps a sticky, active-low break flag. It also drives the block's output clock. That clock is either the synthesized clock or a divided copy of the reference clock, and the switch between the two goes through a glitch-free clock multiplexer. The core itself is outside the block; it is seen only through a `core_lock` input, and the block drives the core's start, multiplier and divider settings.

Software writes the enable, break-policy, multiplier and divider fields through a plain write strobe, and reads the register back at any time. After enable is set, the block stays in the acquiring state and outputs the bypass clock until the core reports lock, which reaches the block through a two-flop synchronizer. The block then enters lock mode. The break-policy bit decides what happens if lock is lost afterwards. Either the block drops back to acquiring on the bypass clock, or it keeps the synthesized clock running and only clears the break flag. There is no data stream, so all pins are plain control and status.

Top module: `pllmode_ctrl`

## Requirements
- R1: After reset the register reads 16'h2002 (break policy 1, break flag 1, everything else 0), and `clk_out` runs at the reference clock rate.
- R2: The register layout is: bit 13 break policy; bits 11:7 multiplier; bits 6:5 lock divider; bit 4 enable; bits 3:2 bypass divider; bit 1 break flag (active low); bit 0 lock status. Bits 15:14 and 12 always read 0. Writes to bits 1:0 and to the reserved bits have no effect.
- R3: Outside lock mode, `clk_out` is the reference clock divided by 1, 2 or 4, for bypass divider codes 00, 01 and 1x.
- R4: With enable set and multiplier of 2 or more, lock status stays 0 until `core_lock` has been high for the two synchronizer cycles. It reads 1 on the third clock edge after `core_lock` rises.
- R5: A write that clears enable makes lock status read 0 and `core_start` fall in the cycle that the write is captured. `clk_out` then returns to the bypass clock.
- R6: With break policy 1, loss of core lock while in lock mode clears lock status and the break flag, and selects the bypass clock. When the core relocks, lock mode resumes and the break flag returns to 1.
- R7: With break policy 0, loss of core lock while in lock mode keeps lock status 1 and keeps the synthesized clock on `clk_out`. Only the break flag goes to 0, and it returns to 1 when the core relocks.
- R8: Any register write sets the break flag back to 1.
- R9: With a multiplier of 0 or 1, the core is not started (`core_start` 0). Enable enters lock mode one cycle after the acquiring state is entered, without waiting for the core. `clk_out` is then the reference clock divided by 1, 2, 3 or 4 for lock divider codes 00, 01, 10 and 11.
- R10: In lock mode with a multiplier of 2 or more, `core_start` is 1 and `clk_out` follows `clk_syn`.
- R11: A write in lock mode that changes the multiplier or the lock divider sends the block back to acquiring (lock status 0) until the core reports lock again. A write that leaves both unchanged does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; clocks the register and mode machine |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_syn | input | 1 | Synthesized clock from the PLL core |
| core_lock | input | 1 | Lock indication from the core (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| core_start | output | 1 | Starts the core's oscillator |
| core_mult | output | 5 | Multiplier setting for the core |
| core_div | output | 2 | Lock divider setting for the core |
| clk_out | output | 1 | Selected output clock |

## Verification
The bench measures the `clk_out` period for every bypass divider code and every lock divider code with the core not started. A divider that decoded `1x` wrongly, or that computed the odd ratio wrongly, would show the wrong edge spacing. It times the rise of lock status cycle by cycle after `core_lock` rises, so a missing synchronizer stage, or an FSM that skipped the wait, would lock early. It drops core lock under both break policies. A design that swapped the policies would drop the synthesized clock when it should keep it, or would leave lock status set after a break. Writes are issued with the multiplier changed and with it unchanged. A design that compared the wrong fields would either never restart acquisition or restart it on every write.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int REG_W    = 16;
  localparam int MULT_W   = 5;
  localparam int LDIV_W   = 2;
  localparam int BDIV_W   = 2;
  localparam int RATIO_W  = 3;
  // bit positions in the control/status word (decoded by software)
  localparam int B_POL    = 13;
  localparam int B_MULT   = 7;
  localparam int B_LDIV   = 5;
  localparam int B_EN     = 4;
  localparam int B_BDIV   = 2;
  localparam int B_BRK    = 1;
  localparam int B_LCK    = 0;

  typedef enum logic [1:0] {
    ST_BYP = 2'd0,
    ST_ACQ = 2'd1,
    ST_LCK = 2'd2
  } pmc_state_e;
endpackage

// File: rtl/pmc_sync.sv
`timescale 1ns/1ps
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_refdiv.sv
`timescale 1ns/1ps
module pmc_refdiv #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               clk_div
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt, cnt_nx;
  logic               div_q;

  always_comb begin
    if (cnt >= ratio - ONE) cnt_nx = '0;
    else                    cnt_nx = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      div_q <= (cnt_nx < (ratio >> 1));
    end
  end

  // divide-by-one passes the reference through
  assign clk_div = (ratio <= ONE) ? clk : div_q;
endmodule

// File: rtl/pmc_gfmux.sv
`timescale 1ns/1ps
module pmc_gfmux (
  input  logic rst_n,
  input  logic clk_a,
  input  logic clk_b,
  input  logic sel_b,
  output logic clk_o
);
  logic a_req, a_en, b_req, b_en;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) a_req <= 1'b0;
    else        a_req <= !sel_b && !b_en;

  always_ff @(negedge clk_a or negedge rst_n)
    if (!rst_n) a_en <= 1'b0;
    else        a_en <= a_req;

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_req <= 1'b0;
    else        b_req <= sel_b && !a_en;

  always_ff @(negedge clk_b or negedge rst_n)
    if (!rst_n) b_en <= 1'b0;
    else        b_en <= b_req;

  assign clk_o = (clk_a && a_en) || (clk_b && b_en);

  always_comb
    AST_MUX_ONE_SIDE: assert (!(a_en && b_en)); // R10
endmodule

// File: rtl/pmc_fsm.sv
`timescale 1ns/1ps
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       en_nx,
  input  logic       restart,
  input  logic       no_core,
  input  logic       pol,
  input  logic       lk_s,
  output pmc_state_e state,
  output logic       brk_n
);
  pmc_state_e state_nx;
  logic       lost;

  assign lost = (state == ST_LCK) && !no_core && !lk_s;

  always_comb begin
    state_nx = state;
    case (state)
      ST_BYP: if (en_nx) state_nx = ST_ACQ;
      ST_ACQ: begin
        if (!en_nx)                state_nx = ST_BYP;
        else if (restart)          state_nx = ST_ACQ;
        else if (no_core || lk_s)  state_nx = ST_LCK;
      end
      ST_LCK: begin
        if (!en_nx)                state_nx = ST_BYP;
        else if (restart)          state_nx = ST_ACQ;
        else if (lost && pol)      state_nx = ST_ACQ;
      end
      default:                     state_nx = ST_BYP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_BYP;
      brk_n <= 1'b1;
    end else begin
      state <= state_nx;
      if (wr_en)     brk_n <= 1'b1;
      else if (lost) brk_n <= 1'b0;
      else if (lk_s) brk_n <= 1'b1;
    end
  end

  AST_WAIT_FOR_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && !lk_s && !no_core) |=> state != ST_LCK); // R4
  AST_DISABLE_TO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_nx |=> state == ST_BYP); // R5
  AST_RELOCK_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LCK && en_nx && pol && !no_core && !lk_s) |=> state == ST_ACQ); // R6
  AST_HOLD_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LCK && en_nx && !restart && !pol && !no_core && !lk_s && !wr_en)
      |=> (state == ST_LCK && !brk_n)); // R7
  AST_WRITE_CLEARS_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> brk_n); // R8
  AST_SETTING_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LCK && en_nx && restart) |=> state == ST_ACQ); // R11
endmodule

// File: rtl/pllmode_ctrl.sv
`timescale 1ns/1ps
module pllmode_ctrl
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              clk_syn,
  input  logic              core_lock,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              core_start,
  output logic [MULT_W-1:0] core_mult,
  output logic [LDIV_W-1:0] core_div,
  output logic              clk_out
);
  logic              pol_q, en_q;
  logic [MULT_W-1:0] mult_q, mult_w;
  logic [LDIV_W-1:0] ldiv_q, ldiv_w;
  logic [BDIV_W-1:0] bdiv_q;
  logic              en_nx, restart, no_core, lk_s, brk_n, sel_syn;
  logic [RATIO_W-1:0] b_ratio, l_ratio, ratio;
  logic              clk_div;
  pmc_state_e        state;

  assign mult_w = wr_data[B_MULT +: MULT_W];
  assign ldiv_w = wr_data[B_LDIV +: LDIV_W];

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b1;
      en_q   <= 1'b0;
      mult_q <= '0;
      ldiv_q <= '0;
      bdiv_q <= '0;
    end else if (wr_en) begin
      pol_q  <= wr_data[B_POL];
      en_q   <= wr_data[B_EN];
      mult_q <= mult_w;
      ldiv_q <= ldiv_w;
      bdiv_q <= wr_data[B_BDIV +: BDIV_W];
    end
  end

  assign en_nx   = wr_en ? wr_data[B_EN] : en_q;
  assign restart = wr_en && ((mult_w != mult_q) || (ldiv_w != ldiv_q));
  assign no_core = (mult_q <= MULT_W'(1));

  pmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(core_lock), .q(lk_s));

  pmc_fsm u_fsm (
    .clk(clk_ref), .rst_n(rst_n), .wr_en(wr_en), .en_nx(en_nx),
    .restart(restart), .no_core(no_core), .pol(pol_q), .lk_s(lk_s),
    .state(state), .brk_n(brk_n));

  always_comb begin
    if (bdiv_q[1])      b_ratio = RATIO_W'(4);
    else if (bdiv_q[0]) b_ratio = RATIO_W'(2);
    else                b_ratio = RATIO_W'(1);
    l_ratio = RATIO_W'(ldiv_q) + RATIO_W'(1);
    ratio   = (state == ST_LCK) ? l_ratio : b_ratio;
  end

  pmc_refdiv #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .ratio(ratio), .clk_div(clk_div));

  assign sel_syn = (state == ST_LCK) && !no_core;

  pmc_gfmux u_mux (
    .rst_n(rst_n), .clk_a(clk_div), .clk_b(clk_syn), .sel_b(sel_syn),
    .clk_o(clk_out));

  assign core_start = (state != ST_BYP) && !no_core;
  assign core_mult  = mult_q;
  assign core_div   = ldiv_q;

  always_comb begin
    rd_data                        = '0;
    rd_data[B_POL]                 = pol_q;
    rd_data[B_MULT +: MULT_W]      = mult_q;
    rd_data[B_LDIV +: LDIV_W]      = ldiv_q;
    rd_data[B_EN]                  = en_q;
    rd_data[B_BDIV +: BDIV_W]      = bdiv_q;
    rd_data[B_BRK]                 = brk_n;
    rd_data[B_LCK]                 = (state == ST_LCK);
  end

  AST_NO_CORE_NO_START: assert property (@(posedge clk_ref) disable iff (!rst_n)
    no_core |-> !core_start); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (rd_data[15:14] == 2'b00) && !rd_data[12]); // R2
endmodule

// File: tb/sim_pllmode_ctrl.sv
`timescale 1ns/1ps
module sim_pllmode_ctrl;
  logic        clk_ref = 1'b0;
  logic        clk_syn = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_lock = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        core_start;
  logic [4:0]  core_mult;
  logic [1:0]  core_div;
  logic        clk_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_ref = ~clk_ref;
  always #3 clk_syn = ~clk_syn;

  pllmode_ctrl u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_syn(clk_syn), .core_lock(core_lock),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .core_start(core_start),
    .core_mult(core_mult), .core_div(core_div), .clk_out(clk_out));

  function automatic logic [15:0] word(input bit pol, input int mult, input int ld,
                                       input bit en, input int bd);
    return (16'(pol) << 13) | (16'(mult) << 7) | (16'(ld) << 5) |
           (16'(en) << 4) | (16'(bd) << 2);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_ref);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk_ref);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  task automatic per(input string tag, input real exp);
    realtime t0, t1;
    real p;
    cyc(24);
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); t1 = $realtime;
    p = t1 - t0;
    n_chk++;
    if (p < exp - 0.01 || p > exp + 0.01) begin
      n_bad++;
      $display("FAIL %s: actual period %0.3f expected %0.3f", tag, p, exp);
    end
  endtask

  initial begin
    #(4.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 reset word", rd_data, 16'h2002);
    per("R1 reset clock", 4.0);

    // R2 layout, reserved and status bits not writable; R4 no lock without core
    wr(16'hFFFF);
    chk("R2 all-ones readback", rd_data, 16'h2FFE);
    cyc(10);
    chk("R4 no lock while core unlocked", {15'd0, rd_data[0]}, 16'd0);
    chk("R10 core started while acquiring", {15'd0, core_start}, 16'd1);
    wr(16'h0000);
    chk("R2 all-zero readback", rd_data, 16'h0002);

    // R3 bypass divider sweep
    for (int b = 0; b < 4; b++) begin
      wr(word(1, 0, 0, 0, b));
      per($sformatf("R3 bypass code %0d", b), 4.0 * ((b >= 2) ? 4 : (b == 1 ? 2 : 1)));
    end

    // R4 lock timing, R10 synthesized clock
    wr(word(1, 6, 0, 1, 0));
    cyc(8);
    chk("R4 still acquiring", {15'd0, rd_data[0]}, 16'd0);
    core_lock = 1'b1;
    cyc(2);
    chk("R4 lock not before sync", {15'd0, rd_data[0]}, 16'd0);
    cyc(1);
    chk("R4 lock after sync", {15'd0, rd_data[0]}, 16'd1);
    chk("R10 core_start in lock", {15'd0, core_start}, 16'd1);
    chk("R10 core_mult", {11'd0, core_mult}, 16'd6);
    per("R10 synthesized clock", 6.0);

    // R6 policy 1 loss
    core_lock = 1'b0;
    cyc(5);
    chk("R6 lock bit drops", {15'd0, rd_data[0]}, 16'd0);
    chk("R6 break flag low", {15'd0, rd_data[1]}, 16'd0);
    per("R6 bypass clock after break", 4.0);
    core_lock = 1'b1;
    cyc(5);
    chk("R6 relocked", rd_data[1:0], 2'b11);

    // R7 policy 0 loss; write with same fields does not restart (R11)
    wr(word(0, 6, 0, 1, 0));
    chk("R11 same-field write keeps lock", {15'd0, rd_data[0]}, 16'd1);
    core_lock = 1'b0;
    cyc(5);
    chk("R7 lock kept", {15'd0, rd_data[0]}, 16'd1);
    chk("R7 break flag low", {15'd0, rd_data[1]}, 16'd0);
    per("R7 synthesized clock kept", 6.0);
    core_lock = 1'b1;
    cyc(5);
    chk("R7 break flag restored", rd_data[1:0], 2'b11);

    // R8 write clears break flag
    core_lock = 1'b0;
    cyc(5);
    chk("R8 break flag set", {15'd0, rd_data[1]}, 16'd0);
    wr(word(0, 6, 0, 1, 0));
    chk("R8 write restores flag", {15'd0, rd_data[1]}, 16'd1);
    chk("R11 unchanged write no restart", {15'd0, rd_data[0]}, 16'd1);

    // R11 changed multiplier restarts acquisition
    wr(word(0, 7, 0, 1, 0));
    chk("R11 restart clears lock", {15'd0, rd_data[0]}, 16'd0);
    cyc(5);
    chk("R11 waits for core", {15'd0, rd_data[0]}, 16'd0);
    core_lock = 1'b1;
    cyc(5);
    chk("R11 relock", {15'd0, rd_data[0]}, 16'd1);

    // R5 clearing enable
    wr(word(0, 7, 0, 0, 1));
    chk("R5 lock cleared", {15'd0, rd_data[0]}, 16'd0);
    chk("R5 core stopped", {15'd0, core_start}, 16'd0);
    per("R5 bypass clock", 8.0);

    // R9 no-core lock with lock divider sweep
    core_lock = 1'b0;
    for (int l = 0; l < 4; l++) begin
      wr(word(1, l & 1, l, 1, 2));
      cyc(2);
      chk($sformatf("R9 lock without core ld %0d", l), {15'd0, rd_data[0]}, 16'd1);
      chk($sformatf("R9 core idle ld %0d", l), {15'd0, core_start}, 16'd0);
      per($sformatf("R9 lock divider code %0d", l), 4.0 * (l + 1));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule